// File: doc/BRIEF.md
# Trace Event Qualifier

This block sits beside a bus monitor and decides, one transaction at a time, whether the current transaction goes into a circular trace memory. A set of control inputs defines the rules. There is a master enable and a halt. There are ignore bits for the address comparison and for the transaction-type comparison. The current context can be qualified as equal to, or as different from, a programmed value. The source ID and the target ID can each be compared against programmed values. A two-bit mode chooses between recording every valid transaction and recording only event cycles.

An event is the AND of every criterion that is switched on. It is also gated by the enable and by the transaction valid strobe. The write strobe is combinational and appears in the same cycle as the transaction. The write pointer names the trace slot for the current write, advances on the clock edge that ends a recorded cycle, and wraps modulo the buffer depth. The active flag is registered: it follows the enable one cycle later, and the halt input does not clear it.

Top module: `trace_qual_top`

## Requirements
- R1: While `cfg_enable` is 0, `trace_wr` stays 0 whatever the other inputs are.
- R2: In mode 2'b00, with the block enabled and not halted, `trace_wr` equals `txn_valid` in the same cycle, and no comparison criterion has any influence on it.
- R3: In mode 2'b10, with `cfg_addr_ignore` at 0, a write needs `txn_addr == cmp_addr`. With `cfg_addr_ignore` at 1, the address has no influence.
- R4: In mode 2'b10, with `cfg_type_ignore` at 0, a write needs `txn_type == cmp_type`. With `cfg_type_ignore` at 1, the type has no influence.
- R5: With `cfg_ctx_eq_en` at 1, an event needs `txn_ctx == cmp_ctx`.
- R6: With `cfg_ctx_ne_en` at 1, an event needs `txn_ctx != cmp_ctx`. With both context qualifiers at 1, no event and no mode-2'b10 write occurs.
- R7: With `cfg_src_en` at 1, an event needs `txn_src == cmp_src`.
- R8: With `cfg_dst_en` at 1 and `cfg_if_sel` all zeros, an event needs `txn_dst == cmp_dst`. When `cfg_if_sel` is nonzero, the target ID has no influence.
- R9: The reserved modes 2'b01 and 2'b11 never assert `trace_wr`.
- R10: While `cfg_halt` is 1, `trace_wr` is 0 in that same cycle, and `trace_active` keeps following the enable.
- R11: In mode 2'b10, with both ignore bits at 1 and all four qualifier enables at 0, every valid transaction is written.
- R12: `trace_ptr` resets to 0. It rises by one after each cycle with `trace_wr` at 1, goes from DEPTH-1 back to 0, and holds when there is no write.
- R13: `trace_active` resets to 0 and takes the value of `cfg_enable` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Master enable |
| cfg_addr_ignore | input | 1 | Skip the address comparison |
| cfg_type_ignore | input | 1 | Skip the transaction-type comparison |
| cfg_ctx_eq_en | input | 1 | Require the context to equal the programmed value |
| cfg_ctx_ne_en | input | 1 | Require the context to differ from the programmed value |
| cfg_src_en | input | 1 | Require a source ID match |
| cfg_dst_en | input | 1 | Require a target ID match |
| cfg_halt | input | 1 | Stop recording at once |
| cfg_mode | input | 2 | 00 all valid, 10 events only, 01/11 reserved |
| cfg_if_sel | input | IFSEL_W | Interface select; the target ID comparison applies only when it is zero |
| txn_valid | input | 1 | Transaction valid strobe |
| txn_addr | input | ADDR_W | Transaction address |
| txn_type | input | TYPE_W | Transaction type |
| txn_ctx | input | CTX_W | Current context |
| txn_src | input | ID_W | Source ID |
| txn_dst | input | ID_W | Target ID |
| cmp_addr | input | ADDR_W | Programmed address |
| cmp_type | input | TYPE_W | Programmed type |
| cmp_ctx | input | CTX_W | Programmed context |
| cmp_src | input | ID_W | Programmed source ID |
| cmp_dst | input | ID_W | Programmed target ID |
| trace_wr | output | 1 | Trace memory write strobe |
| trace_ptr | output | PTR_W | Slot index for the current write |
| trace_active | output | 1 | Tracing active flag |

## Verification
The bench drives both context qualifiers at once. A design that simply ANDed the two terms would get the right answer here only by accident, and one that gave priority to either qualifier would record transactions. It drives the reserved mode codes with every criterion matching, where a decoder that only tests the top mode bit would write. It holds `cfg_if_sel` nonzero with a target mismatch; a design that applied the target comparison regardless would drop that event. It also steps the pointer through the wrap and holds `cfg_halt` while enabled, which catches an off-by-one ring, a pointer that does not hold when there is no write, and a halt that clears the active flag or acts one cycle late.

// File: rtl/trace_qual_pkg.sv
package trace_qual_pkg;

  localparam logic [1:0] TMODE_ALL = 2'b00;
  localparam logic [1:0] TMODE_EVT = 2'b10;

  // A criterion passes when it is switched off or its comparison hits.
  function automatic logic crit_pass(input logic on, input logic hit);
    return !on || hit;
  endfunction

  // Next ring slot for a ring of any depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic logic mode_is_all(input logic [1:0] m);
    return m == TMODE_ALL;
  endfunction

  function automatic logic mode_is_evt(input logic [1:0] m);
    return m == TMODE_EVT;
  endfunction

endpackage

// File: rtl/trace_cmp.sv
module trace_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  assign hit = (a == b);
endmodule

// File: rtl/trace_match_unit.sv
module trace_match_unit
  import trace_qual_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 5,
  parameter int CTX_W   = 8,
  parameter int ID_W    = 6,
  parameter int IFSEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_addr_ignore,
  input  logic               cfg_type_ignore,
  input  logic               cfg_ctx_eq_en,
  input  logic               cfg_ctx_ne_en,
  input  logic               cfg_src_en,
  input  logic               cfg_dst_en,
  input  logic [IFSEL_W-1:0] cfg_if_sel,
  input  logic               txn_valid,
  input  logic [ADDR_W-1:0]  txn_addr,
  input  logic [TYPE_W-1:0]  txn_type,
  input  logic [CTX_W-1:0]   txn_ctx,
  input  logic [ID_W-1:0]    txn_src,
  input  logic [ID_W-1:0]    txn_dst,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [TYPE_W-1:0]  cmp_type,
  input  logic [CTX_W-1:0]   cmp_ctx,
  input  logic [ID_W-1:0]    cmp_src,
  input  logic [ID_W-1:0]    cmp_dst,
  output logic               ev_hit
);

  logic addr_hit, type_hit, ctx_hit, src_hit, dst_hit;
  logic ctx_conflict, dst_applies, crit_all;

  trace_cmp #(.W(ADDR_W)) u_addr (.a(txn_addr), .b(cmp_addr), .hit(addr_hit));
  trace_cmp #(.W(TYPE_W)) u_type (.a(txn_type), .b(cmp_type), .hit(type_hit));
  trace_cmp #(.W(CTX_W))  u_ctx  (.a(txn_ctx),  .b(cmp_ctx),  .hit(ctx_hit));
  trace_cmp #(.W(ID_W))   u_src  (.a(txn_src),  .b(cmp_src),  .hit(src_hit));
  trace_cmp #(.W(ID_W))   u_dst  (.a(txn_dst),  .b(cmp_dst),  .hit(dst_hit));

  // Both context qualifiers at once is a forbidden setup that suppresses events.
  assign ctx_conflict = cfg_ctx_eq_en && cfg_ctx_ne_en;
  // The target ID comparison counts only when the interface select is zero.
  assign dst_applies  = cfg_dst_en && (cfg_if_sel == '0);

  assign crit_all = crit_pass(!cfg_addr_ignore, addr_hit)
                 && crit_pass(!cfg_type_ignore, type_hit)
                 && crit_pass(cfg_ctx_eq_en,    ctx_hit)
                 && crit_pass(cfg_ctx_ne_en,    !ctx_hit)
                 && crit_pass(cfg_src_en,       src_hit)
                 && crit_pass(dst_applies,      dst_hit);

  assign ev_hit = cfg_enable && txn_valid && !ctx_conflict && crit_all;

  assert_addr_need_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !cfg_addr_ignore) |-> (txn_addr == cmp_addr));
  assert_type_need_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !cfg_type_ignore) |-> (txn_type == cmp_type));
  assert_ctx_eq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && cfg_ctx_eq_en) |-> (txn_ctx == cmp_ctx));
  assert_ctx_conflict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctx_eq_en && cfg_ctx_ne_en) |-> !ev_hit);
  assert_src_need_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && cfg_src_en) |-> (txn_src == cmp_src));

endmodule

// File: rtl/trace_record_ctrl.sv
module trace_record_ctrl
  import trace_qual_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_halt,
  input  logic [1:0]       cfg_mode,
  input  logic             txn_valid,
  input  logic             ev_hit,
  output logic             trace_wr,
  output logic [PTR_W-1:0] trace_ptr,
  output logic             trace_active
);

  logic want_rec;

  always_comb begin
    want_rec = 1'b0;
    if (mode_is_all(cfg_mode))      want_rec = txn_valid;
    else if (mode_is_evt(cfg_mode)) want_rec = ev_hit;
  end

  assign trace_wr = cfg_enable && !cfg_halt && want_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trace_ptr    <= '0;
      trace_active <= 1'b0;
    end else begin
      trace_active <= cfg_enable;
      if (trace_wr) trace_ptr <= PTR_W'(ring_next(32'(trace_ptr), DEPTH));
    end
  end

  assert_no_wr_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !trace_wr);
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[0] |-> !trace_wr);
  assert_halt_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_halt |-> !trace_wr);
  assert_ptr_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_wr && trace_ptr == PTR_W'(DEPTH - 1)) |=> (trace_ptr == '0));
  assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_wr |=> $stable(trace_ptr));
  assert_active_on_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable |=> trace_active);
  assert_active_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !trace_active);

endmodule

// File: rtl/trace_qual_top.sv
module trace_qual_top #(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 5,
  parameter int CTX_W   = 8,
  parameter int ID_W    = 6,
  parameter int IFSEL_W = 2,
  parameter int DEPTH   = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_addr_ignore,
  input  logic               cfg_type_ignore,
  input  logic               cfg_ctx_eq_en,
  input  logic               cfg_ctx_ne_en,
  input  logic               cfg_src_en,
  input  logic               cfg_dst_en,
  input  logic               cfg_halt,
  input  logic [1:0]         cfg_mode,
  input  logic [IFSEL_W-1:0] cfg_if_sel,
  input  logic               txn_valid,
  input  logic [ADDR_W-1:0]  txn_addr,
  input  logic [TYPE_W-1:0]  txn_type,
  input  logic [CTX_W-1:0]   txn_ctx,
  input  logic [ID_W-1:0]    txn_src,
  input  logic [ID_W-1:0]    txn_dst,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [TYPE_W-1:0]  cmp_type,
  input  logic [CTX_W-1:0]   cmp_ctx,
  input  logic [ID_W-1:0]    cmp_src,
  input  logic [ID_W-1:0]    cmp_dst,
  output logic               trace_wr,
  output logic [PTR_W-1:0]   trace_ptr,
  output logic               trace_active
);

  logic ev_hit;

  trace_match_unit #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .CTX_W(CTX_W), .ID_W(ID_W), .IFSEL_W(IFSEL_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_addr_ignore(cfg_addr_ignore),
    .cfg_type_ignore(cfg_type_ignore), .cfg_ctx_eq_en(cfg_ctx_eq_en),
    .cfg_ctx_ne_en(cfg_ctx_ne_en), .cfg_src_en(cfg_src_en),
    .cfg_dst_en(cfg_dst_en), .cfg_if_sel(cfg_if_sel),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_type(txn_type),
    .txn_ctx(txn_ctx), .txn_src(txn_src), .txn_dst(txn_dst),
    .cmp_addr(cmp_addr), .cmp_type(cmp_type), .cmp_ctx(cmp_ctx),
    .cmp_src(cmp_src), .cmp_dst(cmp_dst),
    .ev_hit(ev_hit)
  );

  trace_record_ctrl #(.DEPTH(DEPTH)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_halt(cfg_halt), .cfg_mode(cfg_mode),
    .txn_valid(txn_valid), .ev_hit(ev_hit),
    .trace_wr(trace_wr), .trace_ptr(trace_ptr), .trace_active(trace_active)
  );

endmodule

// File: tb/tb_trace_qual_top.sv
module tb_trace_qual_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, TYPE_W = 5, CTX_W = 8, ID_W = 6, IFSEL_W = 2, DEPTH = 16;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int NVEC = 23;

  // {req[3:0], en, aign, tign, ceq, cne, sen, ten, halt, mode[1:0], ifs_zero,
  //  addr_hit, type_hit, ctx_hit, src_hit, dst_hit, expected_wr}
  localparam logic [20:0] VEC [NVEC] = '{
    21'b0001_0_0_0_0_0_0_0_0_00_1_11111_0, // R1 disabled
    21'b0010_1_0_0_1_0_1_1_0_00_1_00000_1, // R2 all-valid mode ignores misses
    21'b0011_1_0_1_0_0_0_0_0_10_1_00000_0, // R3 address miss
    21'b0011_1_0_1_0_0_0_0_0_10_1_10000_1, // R3 address hit
    21'b0100_1_1_0_0_0_0_0_0_10_1_00000_0, // R4 type miss
    21'b0100_1_1_0_0_0_0_0_0_10_1_01000_1, // R4 type hit
    21'b0100_1_0_0_0_0_0_0_0_10_1_10000_0, // R4 addr hit, type miss
    21'b0101_1_1_1_1_0_0_0_0_10_1_00000_0, // R5 ctx differs
    21'b0101_1_1_1_1_0_0_0_0_10_1_00100_1, // R5 ctx equal
    21'b0110_1_1_1_0_1_0_0_0_10_1_00100_0, // R6 ne, ctx equal
    21'b0110_1_1_1_0_1_0_0_0_10_1_00000_1, // R6 ne, ctx differs
    21'b0110_1_1_1_1_1_0_0_0_10_1_00000_0, // R6 both set, ctx differs
    21'b0110_1_1_1_1_1_0_0_0_10_1_00100_0, // R6 both set, ctx equal
    21'b0111_1_1_1_0_0_1_0_0_10_1_00000_0, // R7 src miss
    21'b0111_1_1_1_0_0_1_0_0_10_1_00010_1, // R7 src hit
    21'b1000_1_1_1_0_0_0_1_0_10_1_00000_0, // R8 dst miss, sel zero
    21'b1000_1_1_1_0_0_0_1_0_10_1_00001_1, // R8 dst hit
    21'b1000_1_1_1_0_0_0_1_0_10_0_00000_1, // R8 sel nonzero, dst ignored
    21'b1001_1_1_1_0_0_0_0_0_01_1_11111_0, // R9 mode 01
    21'b1001_1_1_1_0_0_0_0_0_11_1_11111_0, // R9 mode 11
    21'b1010_1_1_1_0_0_0_0_1_00_1_11111_0, // R10 halt
    21'b1011_1_1_1_0_0_0_0_0_10_1_00000_1, // R11 nothing enabled
    21'b0011_1_0_0_0_0_0_0_0_10_1_11111_1  // R3 addr and type both required and met
  };

  logic clk = 1'b0, rst_n;
  logic cfg_enable, cfg_addr_ignore, cfg_type_ignore, cfg_ctx_eq_en, cfg_ctx_ne_en;
  logic cfg_src_en, cfg_dst_en, cfg_halt;
  logic [1:0] cfg_mode;
  logic [IFSEL_W-1:0] cfg_if_sel;
  logic txn_valid;
  logic [ADDR_W-1:0] txn_addr, cmp_addr;
  logic [TYPE_W-1:0] txn_type, cmp_type;
  logic [CTX_W-1:0]  txn_ctx, cmp_ctx;
  logic [ID_W-1:0]   txn_src, cmp_src, txn_dst, cmp_dst;
  logic trace_wr, trace_active;
  logic [PTR_W-1:0] trace_ptr;

  int total = 0, bad = 0, exp_ptr = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_qual_top #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .CTX_W(CTX_W), .ID_W(ID_W),
                   .IFSEL_W(IFSEL_W), .DEPTH(DEPTH)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_cfg();
    cfg_enable = 0; cfg_addr_ignore = 0; cfg_type_ignore = 0; cfg_ctx_eq_en = 0;
    cfg_ctx_ne_en = 0; cfg_src_en = 0; cfg_dst_en = 0; cfg_halt = 0;
    cfg_mode = 2'b00; cfg_if_sel = '0; txn_valid = 0;
    txn_addr = cmp_addr; txn_type = cmp_type; txn_ctx = cmp_ctx;
    txn_src = cmp_src; txn_dst = cmp_dst;
  endtask

  task automatic apply_vec(input logic [20:0] v);
    cfg_enable = v[16]; cfg_addr_ignore = v[15]; cfg_type_ignore = v[14];
    cfg_ctx_eq_en = v[13]; cfg_ctx_ne_en = v[12]; cfg_src_en = v[11];
    cfg_dst_en = v[10]; cfg_halt = v[9]; cfg_mode = v[8:7];
    cfg_if_sel = v[6] ? '0 : IFSEL_W'(1);
    txn_valid = 1'b1;
    txn_addr = v[5] ? cmp_addr : cmp_addr ^ 1;
    txn_type = v[4] ? cmp_type : cmp_type ^ 1;
    txn_ctx  = v[3] ? cmp_ctx  : cmp_ctx  ^ 1;
    txn_src  = v[2] ? cmp_src  : cmp_src  ^ 1;
    txn_dst  = v[1] ? cmp_dst  : cmp_dst  ^ 1;
  endtask

  initial begin
    cmp_addr = 32'h4000_1230; cmp_type = 5'h0b; cmp_ctx = 8'h5a;
    cmp_src = 6'h13; cmp_dst = 6'h2c;
    idle_cfg();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset active", 32'(trace_active), 0);
    check("R12 reset ptr", 32'(trace_ptr), 0);
    check("R1 reset wr", 32'(trace_wr), 0);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check($sformatf("R12 ptr before vec%0d", i), 32'(trace_ptr), 32'(exp_ptr));
      apply_vec(VEC[i]);
      #1;
      check($sformatf("R%0d vec%0d wr", VEC[i][20:17], i), 32'(trace_wr), 32'(VEC[i][0]));
      if (VEC[i][0]) exp_ptr = (exp_ptr + 1) % DEPTH;
    end

    // R2: no valid, no write; R12: pointer holds
    @(negedge clk);
    check("R12 ptr after table", 32'(trace_ptr), 32'(exp_ptr));
    idle_cfg(); cfg_enable = 1; cfg_mode = 2'b00; txn_valid = 0;
    #1 check("R2 invalid not written", 32'(trace_wr), 0);
    @(negedge clk);
    check("R12 ptr holds", 32'(trace_ptr), 32'(exp_ptr));
    check("R13 active while enabled", 32'(trace_active), 1);

    // R10: halt stops writes at once, active stays
    cfg_halt = 1; txn_valid = 1;
    #1 check("R10 halt blocks wr", 32'(trace_wr), 0);
    @(negedge clk);
    check("R10 active kept under halt", 32'(trace_active), 1);
    check("R10 ptr still", 32'(trace_ptr), 32'(exp_ptr));

    // R13: active follows enable one clock later
    cfg_halt = 0; cfg_enable = 0;
    #1 check("R13 active lags drop", 32'(trace_active), 1);
    check("R1 disabled wr", 32'(trace_wr), 0);
    @(negedge clk);
    check("R13 active cleared", 32'(trace_active), 0);
    cfg_enable = 1; txn_valid = 0;
    #1 check("R13 active lags rise", 32'(trace_active), 0);
    @(negedge clk);
    check("R13 active set", 32'(trace_active), 1);

    // R12: run through the wrap
    txn_valid = 1;
    for (int k = 0; k < DEPTH + 3; k++) begin
      #1 check("R2 stream wr", 32'(trace_wr), 1);
      @(negedge clk);
      exp_ptr = (exp_ptr + 1) % DEPTH;
      check($sformatf("R12 ring step%0d", k), 32'(trace_ptr), 32'(exp_ptr));
    end
    txn_valid = 0;
    @(negedge clk);
    check("R12 ptr holds after stream", 32'(trace_ptr), 32'(exp_ptr));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule